// File: doc/BRIEF.md
# Tagged Local-History Branch Predictor

This block predicts the direction of conditional branches from each branch's own recent behaviour. A set-associative table holds one entry per tracked branch. An entry is tagged by the branch's fetch address and keeps a short shift register of that branch's latest outcomes. That history picks one of sixteen 2-bit saturating counters private to the entry, and the counter's upper bit is the prediction.

A fetch stage presents an address on the lookup port. In the same cycle it gets back a hit flag and a taken or not-taken guess. When the branch resolves, the execute stage presents the branch's address and its real outcome on the update port. The table then trains the entry or, for a branch not yet tracked that turned out taken, creates a new entry. Within each set a rotating victim pointer chooses which way a new entry overwrites.

Top module: `lhist_bpred`

## Requirements
- R1: After reset no entry is present, so every lookup reports lk_hit=0 until a taken update has been made.
- R2: A lookup that misses reports lk_hit=0 and lk_taken=0.
- R3: With word-aligned addresses, the set is addr[8:2] and the tag is addr[31:9]. A lookup hits only when a valid entry in that set holds the same tag, so an address with the same set bits but a different tag misses.
- R4: A taken update for an address not in the table creates an entry. Its history is 4'b1111, the counter for pattern 1111 is 2'b10, and the other fifteen counters are 2'b01. From the next cycle a lookup of that address hits and predicts taken.
- R5: A not-taken update for an address not in the table changes nothing.
- R6: On a hit, lk_taken is the upper bit of the counter selected by the entry's current history: 2'b10 and 2'b11 give taken, 2'b00 and 2'b01 give not taken.
- R7: An update that hits moves the selected counter one step toward the outcome (00, 01, 10, 11), holding at 00 and at 11.
- R8: The counter trained by an update is the one selected by the history before that update. The history then shifts left, with the outcome (1 for taken) entering bit 0.
- R9: Each set has a 2-bit victim pointer that reset sets to way 0. An allocation writes the pointed way and advances the pointer by one, modulo 4. The entry it overwrites then misses.
- R10: The lookup outputs reflect the table as it stood before an update in the same cycle. The update becomes visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_addr | input | 32 | Fetch address to predict |
| lk_hit | output | 1 | An entry matches lk_addr |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A lookup and an update can fall in the same cycle, and they can target the very entry being trained or allocated. The stimulus deliberately drives both ports with the same address: a directed case for a fresh allocation, plus random steps in which the lookup address is often copied from the update address. The lookup result is sampled before the clock edge and compared with a bench model that has not yet applied the update. After the edge, the following lookup is checked against the updated model, so any forwarding or any lost write shows up as a mismatch.

// File: rtl/lhist_bpred.sv
module lhist_bpred #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int HIST_W = 4,
  parameter int ALIGN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_taken,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - ALIGN;
  localparam int PAT   = 1 << HIST_W;
  localparam int CTR_W = 2 * PAT;
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [CTR_W-1:0] CTR_INIT = {2'b10, {(PAT-1){2'b01}}};

  logic              vld_q  [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [HIST_W-1:0] hist_q [SETS][WAYS];
  logic [CTR_W-1:0]  ctr_q  [SETS][WAYS];
  logic [WAY_W-1:0]  rr_q   [SETS];

  wire [IDX_W-1:0] ls = lk_addr[ALIGN +: IDX_W];
  wire [TAG_W-1:0] lt = lk_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] us = upd_addr[ALIGN +: IDX_W];
  wire [TAG_W-1:0] ut = upd_addr[ADDR_W-1 -: TAG_W];

  function automatic logic [1:0] step_ctr(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    else   return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  always_comb begin
    lk_hit   = 1'b0;
    lk_taken = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[ls][w] && tag_q[ls][w] == lt) begin
        lk_hit   = 1'b1;
        lk_taken = ctr_q[ls][w][2*hist_q[ls][w] + 1];
      end
    end
  end

  logic             u_hit;
  logic [WAY_W-1:0] u_way;
  always_comb begin
    u_hit = 1'b0;
    u_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[us][w] && tag_q[us][w] == ut) begin
        u_hit = 1'b1;
        u_way = WAY_W'(w);
      end
    end
  end

  logic [HIST_W-1:0] u_hist;
  logic [CTR_W-1:0]  u_ctr;
  always_comb begin
    u_hist = hist_q[us][u_way];
    u_ctr  = ctr_q[us][u_way];
    u_ctr[2*u_hist +: 2] = step_ctr(ctr_q[us][u_way][2*u_hist +: 2], upd_taken);
  end

  wire [WAY_W-1:0] vict = rr_q[us];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) vld_q[s][w] <= 1'b0;
      end
    end else if (upd_valid) begin
      if (u_hit) begin
        ctr_q[us][u_way]  <= u_ctr;
        hist_q[us][u_way] <= {u_hist[HIST_W-2:0], upd_taken};
      end else if (upd_taken) begin
        vld_q[us][vict]  <= 1'b1;
        tag_q[us][vict]  <= ut;
        hist_q[us][vict] <= '1;
        ctr_q[us][vict]  <= CTR_INIT;
        rr_q[us]         <= vict + WAY_W'(1);
      end
    end
  end
endmodule

// File: rtl/lhist_bpred_chk.sv
module lhist_bpred_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic              lk_taken,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_addr,
  input logic              upd_taken
);
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);

  a_r2_miss_not_taken: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> !lk_taken);

  a_r4_taken_allocates: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken) |=> (lk_addr != $past(upd_addr)) || lk_hit);

  a_r5_not_taken_miss_ignored: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken && !lk_hit && lk_addr == upd_addr)
      |=> (lk_addr != $past(upd_addr)) || !lk_hit);

  a_r10_quiet_table: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> !$stable(lk_addr) || ($stable(lk_hit) && $stable(lk_taken)));
endmodule

bind lhist_bpred lhist_bpred_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_taken(lk_taken),
  .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken)
);

// File: tb/lhist_bpred_tb.sv
module lhist_bpred_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_addr = '0;
  logic        lk_hit, lk_taken;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_addr = '0;
  logic        upd_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lhist_bpred u_dut (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken)
  );

  bit         m_vld  [128][4];
  bit [22:0]  m_tag  [128][4];
  bit [3:0]   m_hist [128][4];
  bit [1:0]   m_ctr  [128][4][16];
  bit [1:0]   m_rr   [128];

  function automatic int find(input logic [31:0] a);
    for (int w = 0; w < 4; w++)
      if (m_vld[a[8:2]][w] && m_tag[a[8:2]][w] == a[31:9]) return w;
    return -1;
  endfunction

  function automatic void m_reset();
    for (int s = 0; s < 128; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
    end
  endfunction

  function automatic void m_update(input logic [31:0] a, input bit t);
    int w = find(a);
    int s = a[8:2];
    if (w >= 0) begin
      bit [3:0] h = m_hist[s][w];
      if (t && m_ctr[s][w][h] != 2'b11) m_ctr[s][w][h]++;
      if (!t && m_ctr[s][w][h] != 2'b00) m_ctr[s][w][h]--;
      m_hist[s][w] = {h[2:0], t};
    end else if (t) begin
      w = m_rr[s];
      m_vld[s][w] = 1; m_tag[s][w] = a[31:9]; m_hist[s][w] = 4'hF;
      for (int p = 0; p < 16; p++) m_ctr[s][w][p] = (p == 15) ? 2'b10 : 2'b01;
      m_rr[s] = m_rr[s] + 2'd1;
    end
  endfunction

  task automatic check(input string req, input bit got_h, input bit got_t,
                       input bit exp_h, input bit exp_t);
    checks++;
    if (got_h !== exp_h || got_t !== exp_t) begin
      errors++;
      $display("FAIL %s hit/taken actual %0b/%0b expected %0b/%0b", req, got_h, got_t, exp_h, exp_t);
    end
  endtask

  task automatic step(input string req, input logic [31:0] la, input bit uv,
                      input logic [31:0] ua, input bit ut);
    int w;
    bit eh, et;
    @(negedge clk);
    lk_addr = la; upd_valid = uv; upd_addr = ua; upd_taken = ut;
    #1;
    w = find(la);
    eh = (w >= 0);
    et = eh ? m_ctr[la[8:2]][w][m_hist[la[8:2]][w]][1] : 1'b0;
    check(req, lk_hit, lk_taken, eh, et);
    @(posedge clk);
    if (uv) m_update(ua, ut);
  endtask

  function automatic logic [31:0] mk(input int tag, input int idx);
    return {23'(tag), 7'(idx), 2'b00};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'h1b2c3d));
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state, R2 miss
    step("R1", mk(1, 3), 0, '0, 0);
    check("R2", lk_hit, lk_taken, 0, 0);
    // R5 not-taken miss ignored
    step("R5", mk(1, 3), 1, mk(1, 3), 0);
    step("R5", mk(1, 3), 0, '0, 0);
    // R10 same-cycle lookup and allocate: old state seen
    step("R10", mk(1, 3), 1, mk(1, 3), 1);
    // R4 allocated entry hits and predicts taken
    step("R4", mk(1, 3), 0, '0, 0);
    check("R4", lk_hit, lk_taken, 1, 1);
    // R3 same set, different tag misses
    step("R3", mk(2, 3), 0, '0, 0);
    check("R3", lk_hit, lk_taken, 0, 0);
    // R7 saturate at 11, R8 history shift selects counter 14 (=01)
    step("R7", mk(1, 3), 1, mk(1, 3), 1);
    step("R7", mk(1, 3), 1, mk(1, 3), 1);
    step("R8", mk(1, 3), 1, mk(1, 3), 0);
    step("R6", mk(1, 3), 0, '0, 0);
    check("R8", lk_hit, lk_taken, 1, 0);
    // R9 round-robin eviction in set 77
    for (int t = 10; t < 15; t++) step("R9", mk(t, 77), 1, mk(t, 77), 1);
    step("R9", mk(10, 77), 0, '0, 0);
    check("R9", lk_hit, lk_taken, 0, 0);
    step("R9", mk(11, 77), 1, mk(10, 77), 1);
    step("R9", mk(11, 77), 0, '0, 0);
    check("R9", lk_hit, lk_taken, 0, 0);
    step("R9", mk(14, 77), 0, '0, 0);
    // R7 drive a counter down to 00 and hold
    for (int i = 0; i < 6; i++) step("R7", mk(14, 77), 1, mk(14, 77), 0);
    // random mix over a small pool of conflicting addresses
    for (int i = 0; i < 3000; i++) begin
      a = mk($urandom_range(0, 6), ($urandom_range(0, 1) != 0) ? 3 : 77);
      b = ($urandom_range(0, 2) == 0) ? a : mk($urandom_range(0, 6), ($urandom_range(0, 1) != 0) ? 3 : 77);
      step("R6 R7 R8 R9 R10", b, $urandom_range(0, 3) != 0, a, $urandom_range(0, 2) != 0);
    end
    // R1 reset clears the table again
    @(negedge clk); rst = 1; upd_valid = 0;
    @(posedge clk); m_reset();
    @(negedge clk); rst = 0;
    step("R1", mk(1, 3), 0, '0, 0);
    check("R1", lk_hit, lk_taken, 0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule